// File: doc/BRIEF.md
# Count-to-Limit Interval Timer Pair

This block provides a parameterised set of up-counting interval timers, two by default, that a processor reaches through a small auxiliary register bus. The bus has a write strobe, a read strobe, an address and a data word. Each timer has three registers: a count, a limit and a two-bit control word.

While it is allowed to advance, a timer's count goes up by one on every clock. When the count equals the limit, the next advance loads zero instead. If interrupts are enabled, that wrap also sets a pending flag, and the flag drives the timer's level interrupt line. The flag stays set until software writes anything to that timer's control register. A control bit can tie counting to the processor's halt signal, so that a debugger stopping the core also stops the timer.

One instance is usually given a short limit and used to produce periodic ticks. The other is left at the all-ones limit and used as a free-running timestamp.

Top module: `aux_interval_timers`

## Requirements
- R1: After reset every count is 0, every control word is 0, every limit is 0xFFFFFFFF and every irq line is low.
- R2: Timer 0 decodes count at 0x021, control at 0x022 and limit at 0x023; timer 1 decodes count at 0x100, control at 0x101 and limit at 0x102. A read returns on aux_rdata_o in the cycle after the one with aux_rd_i high, and shows 0 when aux_rd_i was low. Control reads show IE in bit 0 and NH in bit 1, with zeros above; upper bits written to control are dropped. A read of any other address returns 0.
- R3: Each advancing cycle raises the count by exactly 1 while the count differs from the limit.
- R4: An advancing cycle in which the count equals the limit loads 0 into the count.
- R5: With control bit 0 (IE) set, a wrap sets the timer's pending flag, and irq_o[i] equals that flag. With IE clear, a wrap leaves the flag unchanged. The flag stays set across later wraps.
- R6: With control bit 1 (NH) set and cpu_halted_i high, the count holds. With NH clear, cpu_halted_i has no effect on counting.
- R7: Any write to a timer's control register clears its pending flag, even in a cycle where a wrap occurs.
- R8: A write to the count register loads the written value, overriding both the increment and the halt freeze in that cycle.
- R9: With the limit at 0xFFFFFFFF the timer runs free: 0xFFFFFFFF is followed by 0.
- R10: A register write to one timer leaves the registers and irq of the other timer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_halted_i | input | 1 | High while the processor is halted |
| aux_wr_i | input | 1 | Register write strobe |
| aux_rd_i | input | 1 | Register read strobe |
| aux_addr_i | input | ADDR_W (12) | Register address |
| aux_wdata_i | input | DATA_W (32) | Write data |
| aux_rdata_o | output | DATA_W (32) | Read data, one cycle after the read strobe |
| irq_o | output | NUM_TIMERS (2) | Level interrupt per timer |

## Verification
Directed sequences come first. The limit is set to 3 so that wraps happen every few cycles, which separates the wrap-to-zero, pending-set and pending-persist behaviour. A control write is placed exactly on the wrap cycle to show that clearing takes priority over setting. Counting under halt is tried with NH set and with NH cleared, which shows that the freeze applies only when NH asks for it, and a count near 0xFFFFFFFF exercises the free-running rollover. A long random phase then mixes writes with small limits, reads of mapped and unmapped addresses, and a toggling halt input. This stresses count-write priority, independence between the timers and every same-cycle collision, all compared against a reference model.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
   // Register offsets from each timer's base address; software depends on them.
   localparam int OFS_COUNT = 0;
   localparam int OFS_CTRL  = 1;
   localparam int OFS_LIMIT = 2;
   localparam int SPAN      = 3;

   // Control word layout
   localparam int CTL_IE_BIT = 0;
   localparam int CTL_NH_BIT = 1;
   localparam int CTL_W      = 2;

   typedef struct packed {
      logic nh;   // bit 1: advance only while the core runs
      logic ie;   // bit 0: wrap raises the pending flag
   } itmr_ctl_t;
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
   import itmr_pkg::*;
#(
   parameter int                ADDR_W = 12,
   parameter logic [ADDR_W-1:0] BASE   = '0
) (
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_cnt_o,
   output logic              hit_ctl_o,
   output logic              hit_lim_o,
   output logic              wr_cnt_o,
   output logic              wr_ctl_o,
   output logic              wr_lim_o
);
   localparam logic [ADDR_W-1:0] A_CNT = BASE + ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_CTL = BASE + ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_LIM = BASE + ADDR_W'(OFS_LIMIT);

   assign hit_cnt_o = (addr_i == A_CNT);
   assign hit_ctl_o = (addr_i == A_CTL);
   assign hit_lim_o = (addr_i == A_LIM);

   assign wr_cnt_o = wr_en_i & hit_cnt_o;
   assign wr_ctl_o = wr_en_i & hit_ctl_o;
   assign wr_lim_o = wr_en_i & hit_lim_o;
endmodule

// File: rtl/itmr_core.sv
module itmr_core
   import itmr_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] RST_LIMIT = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              halted_i,
   input  logic              wr_cnt_i,
   input  logic              wr_ctl_i,
   input  logic              wr_lim_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] cnt_o,
   output logic [DATA_W-1:0] lim_o,
   output logic [CTL_W-1:0]  ctl_o,
   output logic              pend_o
);
   logic [DATA_W-1:0] cnt_q, cnt_d, lim_q;
   itmr_ctl_t         ctl_q;
   logic              pend_q, pend_d;
   logic              advance, at_limit, wrap;

   assign advance  = !(ctl_q.nh && halted_i);
   assign at_limit = (cnt_q == lim_q);
   assign wrap     = advance && at_limit && !wr_cnt_i;

   always_comb begin
      cnt_d = cnt_q;
      if (wr_cnt_i)
         cnt_d = wdata_i;
      else if (advance)
         cnt_d = at_limit ? '0 : cnt_q + DATA_W'(1);
   end

   always_comb begin
      pend_d = pend_q;
      if (wr_ctl_i)
         pend_d = 1'b0;
      else if (wrap && ctl_q.ie)
         pend_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         lim_q  <= RST_LIMIT;
         ctl_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         pend_q <= pend_d;
         if (wr_lim_i) lim_q <= wdata_i;
         if (wr_ctl_i) ctl_q <= itmr_ctl_t'(wdata_i[CTL_W-1:0]);
      end
   end

   assign cnt_o  = cnt_q;
   assign lim_o  = lim_q;
   assign ctl_o  = ctl_q;
   assign pend_o = pend_q;

   // R3: ordinary step
   p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (advance && !wr_cnt_i && !at_limit) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));

   // R4: wrap loads zero
   p_wrap_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (advance && !wr_cnt_i && at_limit) |=> (cnt_q == '0));

   // R5: pending set on enabled wrap
   p_pend_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap && ctl_q.ie && !wr_ctl_i) |=> pend_q);

   // R5: no pending without IE
   p_no_pend_without_ie_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_q && !ctl_q.ie) |=> !pend_q);

   // R6: frozen while halted with NH
   p_hold_when_halted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_q.nh && halted_i && !wr_cnt_i) |=> $stable(cnt_q));

   // R7: control write clears pending
   p_ctl_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ctl_i |=> !pend_q);

   // R8: count write wins
   p_cnt_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_cnt_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/itmr_rdmux.sv
module itmr_rdmux
   import itmr_pkg::*;
#(
   parameter int NUM    = 2,
   parameter int DATA_W = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         rd_en_i,
   input  logic [NUM-1:0]               hit_cnt_i,
   input  logic [NUM-1:0]               hit_ctl_i,
   input  logic [NUM-1:0]               hit_lim_i,
   input  logic [NUM-1:0][DATA_W-1:0]   cnt_i,
   input  logic [NUM-1:0][DATA_W-1:0]   lim_i,
   input  logic [NUM-1:0][CTL_W-1:0]    ctl_i,
   output logic [DATA_W-1:0]            rdata_o
);
   localparam int PAD_W = DATA_W - CTL_W;

   logic [DATA_W-1:0] sel;
   logic              any_hit;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM; i++) begin
         if (hit_cnt_i[i]) sel = sel | cnt_i[i];
         if (hit_lim_i[i]) sel = sel | lim_i[i];
         if (hit_ctl_i[i]) sel = sel | {{PAD_W{1'b0}}, ctl_i[i]};
      end
   end

   assign any_hit = |{hit_cnt_i, hit_ctl_i, hit_lim_i};

   generate
      if (REG_OUT) begin : g_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) rdata_q <= '0;
            else         rdata_q <= rd_en_i ? sel : '0;
         end
         assign rdata_o = rdata_q;

         // R2: unmapped or idle read returns zero
         p_unmapped_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!rd_en_i || !any_hit) |=> (rdata_o == '0));
      end else begin : g_comb
         assign rdata_o = rd_en_i ? sel : '0;
         always_comb begin
            if (rst_ni && !any_hit)
               a_unmapped_zero_r2: assert (rdata_o == '0);
         end
      end
   endgenerate
endmodule

// File: rtl/aux_interval_timers.sv
module aux_interval_timers
   import itmr_pkg::*;
#(
   parameter int                           NUM_TIMERS = 2,
   parameter int                           DATA_W     = 32,
   parameter int                           ADDR_W     = 12,
   parameter logic [NUM_TIMERS*ADDR_W-1:0] BASE_ADDRS = {12'h100, 12'h021},
   parameter bit                           REG_RDATA  = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cpu_halted_i,
   input  logic                  aux_wr_i,
   input  logic                  aux_rd_i,
   input  logic [ADDR_W-1:0]     aux_addr_i,
   input  logic [DATA_W-1:0]     aux_wdata_i,
   output logic [DATA_W-1:0]     aux_rdata_o,
   output logic [NUM_TIMERS-1:0] irq_o
);
   localparam logic [DATA_W-1:0] RST_LIMIT = {DATA_W{1'b1}};
   localparam int                ADDR_TOP  = (1 << ADDR_W) - 1;

   // Elaboration-time parameter checks
   generate
      if (NUM_TIMERS < 1) begin : g_bad_num
         $error("aux_interval_timers: NUM_TIMERS must be at least 1");
      end
      if (DATA_W <= CTL_W) begin : g_bad_dw
         $error("aux_interval_timers: DATA_W must exceed the control width");
      end
      if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_aw
         $error("aux_interval_timers: ADDR_W out of range");
      end
      for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk_base
         localparam int BI = int'(BASE_ADDRS[i*ADDR_W +: ADDR_W]);
         if (BI + SPAN - 1 > ADDR_TOP) begin : g_bad_top
            $error("aux_interval_timers: register window leaves the address space");
         end
         for (genvar j = i + 1; j < NUM_TIMERS; j++) begin : g_pair
            localparam int BJ   = int'(BASE_ADDRS[j*ADDR_W +: ADDR_W]);
            localparam int DIST = (BI > BJ) ? (BI - BJ) : (BJ - BI);
            if (DIST < SPAN) begin : g_overlap
               $error("aux_interval_timers: register windows overlap");
            end
         end
      end
   endgenerate

   logic [NUM_TIMERS-1:0]             hit_cnt, hit_ctl, hit_lim;
   logic [NUM_TIMERS-1:0]             wr_cnt, wr_ctl, wr_lim;
   logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_all, lim_all;
   logic [NUM_TIMERS-1:0][CTL_W-1:0]  ctl_all;
   logic [NUM_TIMERS-1:0]             pend_all;

   generate
      for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_timer
         itmr_decode #(
            .ADDR_W (ADDR_W),
            .BASE   (BASE_ADDRS[i*ADDR_W +: ADDR_W])
         ) u_dec (
            .wr_en_i   (aux_wr_i),
            .addr_i    (aux_addr_i),
            .hit_cnt_o (hit_cnt[i]),
            .hit_ctl_o (hit_ctl[i]),
            .hit_lim_o (hit_lim[i]),
            .wr_cnt_o  (wr_cnt[i]),
            .wr_ctl_o  (wr_ctl[i]),
            .wr_lim_o  (wr_lim[i])
         );

         itmr_core #(
            .DATA_W    (DATA_W),
            .RST_LIMIT (RST_LIMIT)
         ) u_core (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .halted_i (cpu_halted_i),
            .wr_cnt_i (wr_cnt[i]),
            .wr_ctl_i (wr_ctl[i]),
            .wr_lim_i (wr_lim[i]),
            .wdata_i  (aux_wdata_i),
            .cnt_o    (cnt_all[i]),
            .lim_o    (lim_all[i]),
            .ctl_o    (ctl_all[i]),
            .pend_o   (pend_all[i])
         );
      end
   endgenerate

   itmr_rdmux #(
      .NUM     (NUM_TIMERS),
      .DATA_W  (DATA_W),
      .REG_OUT (REG_RDATA)
   ) u_rd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_en_i   (aux_rd_i),
      .hit_cnt_i (hit_cnt),
      .hit_ctl_i (hit_ctl),
      .hit_lim_i (hit_lim),
      .cnt_i     (cnt_all),
      .lim_i     (lim_all),
      .ctl_i     (ctl_all),
      .rdata_o   (aux_rdata_o)
   );

   assign irq_o = pend_all;

   // R10: a write to one timer leaves other timers' interrupt lines alone
   generate
      for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_iso
         p_isolated_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (aux_wr_i && !hit_cnt[i] && !hit_ctl[i] && !hit_lim[i] && pend_all[i])
            |=> pend_all[i]);
      end
   endgenerate
endmodule

// File: tb/aux_interval_timers_test.sv
module aux_interval_timers_test;
   localparam int NT = 2;
   localparam int DW = 32;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          halted = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NT-1:0] irq;

   always #10 clk = ~clk;   // 50 MHz

   aux_interval_timers uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .cpu_halted_i (halted),
      .aux_wr_i     (wr_en),
      .aux_rd_i     (rd_en),
      .aux_addr_i   (addr),
      .aux_wdata_i  (wdata),
      .aux_rdata_o  (rdata),
      .irq_o        (irq)
   );

   int checks = 0;
   int fails  = 0;
   bit mon_on = 1'b0;
   bit done   = 1'b0;

   // Reference model built from the requirements
   logic [DW-1:0] m_cnt  [NT];
   logic [DW-1:0] m_lim  [NT];
   logic [1:0]    m_ctl  [NT];
   logic          m_pend [NT];
   logic [DW-1:0] m_rdata;

   function automatic logic [AW-1:0] base_of(int i);
      return (i == 0) ? 12'h021 : 12'h100;
   endfunction

   function automatic logic [DW-1:0] m_read(logic [AW-1:0] a);
      for (int i = 0; i < NT; i++) begin
         if (a == base_of(i))         return m_cnt[i];
         if (a == base_of(i) + 12'd1) return {30'd0, m_ctl[i]};
         if (a == base_of(i) + 12'd2) return m_lim[i];
      end
      return '0;
   endfunction

   function automatic logic m_adv(int i);
      return !(m_ctl[i][1] && halted);
   endfunction

   function automatic logic [DW-1:0] m_next_cnt(int i);
      if (wr_en && addr == base_of(i)) return wdata;
      if (!m_adv(i)) return m_cnt[i];
      if (m_cnt[i] == m_lim[i]) return '0;
      return m_cnt[i] + 32'd1;
   endfunction

   function automatic logic m_next_pend(int i);
      if (wr_en && addr == base_of(i) + 12'd1) return 1'b0;
      if (m_adv(i) && !(wr_en && addr == base_of(i)) &&
          m_cnt[i] == m_lim[i] && m_ctl[i][0]) return 1'b1;
      return m_pend[i];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rdata <= '0;
         for (int i = 0; i < NT; i++) begin
            m_cnt[i] <= '0; m_lim[i] <= '1; m_ctl[i] <= '0; m_pend[i] <= 1'b0;
         end
      end else begin
         m_rdata <= rd_en ? m_read(addr) : '0;
         for (int i = 0; i < NT; i++) begin
            m_cnt[i]  <= m_next_cnt(i);
            m_pend[i] <= m_next_pend(i);
            if (wr_en && addr == base_of(i) + 12'd1) m_ctl[i] <= wdata[1:0];
            if (wr_en && addr == base_of(i) + 12'd2) m_lim[i] <= wdata;
         end
      end
   end

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Continuous comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (mon_on) begin
         chk("R2 model readback", rdata, m_rdata);
         for (int i = 0; i < NT; i++)
            chk("R5 model irq", 32'(irq[i]), 32'(m_pend[i]));
      end
   end

   // All tasks start right after a falling edge and end at one
   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=expired expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      // R1: reset state
      chk("R1 irq after reset", 32'(irq), 32'd0);
      rd(12'h023, v); chk("R1 limit0 reset", v, 32'hFFFF_FFFF);
      rd(12'h022, v); chk("R1 ctrl0 reset", v, 32'd0);
      rd(12'h102, v); chk("R1 limit1 reset", v, 32'hFFFF_FFFF);
      rd(12'h101, v); chk("R1 ctrl1 reset", v, 32'd0);

      // R2: unmapped reads, control field width
      rd(12'h024, v); chk("R2 unmapped 0x024", v, 32'd0);
      rd(12'h0FF, v); chk("R2 unmapped 0x0FF", v, 32'd0);
      wr(12'h022, 32'hFFFF_FFFC);
      rd(12'h022, v); chk("R2 ctrl upper bits dropped", v, 32'd0);

      // R10: independence of the two limit registers
      wr(12'h102, 32'h0000_1234);
      rd(12'h023, v); chk("R10 limit0 untouched", v, 32'hFFFF_FFFF);
      rd(12'h102, v); chk("R2 limit1 readback", v, 32'h0000_1234);

      // R8 and R3: count write, then steps
      wr(12'h023, 32'd1000);
      wr(12'h021, 32'd0);
      rd(12'h021, v); chk("R8 count write visible", v, 32'd0);
      wr(12'h021, 32'd0);
      idle(4);
      rd(12'h021, v); chk("R3 four steps", v, 32'd4);

      // R4, R5: wrap with IE on timer 1
      wr(12'h102, 32'd3);
      wr(12'h101, 32'd1);
      wr(12'h100, 32'd0);
      idle(3);
      chk("R5 no irq before wrap", 32'(irq[1]), 32'd0);
      idle(1);
      chk("R5 irq after wrap", 32'(irq[1]), 32'd1);
      rd(12'h100, v); chk("R4 wrap to zero", v, 32'd0);
      chk("R5 pending holds", 32'(irq[1]), 32'd1);
      chk("R10 timer0 irq quiet", 32'(irq[0]), 32'd0);

      // R7: control write clears
      wr(12'h101, 32'd1);
      chk("R7 control write clears", 32'(irq[1]), 32'd0);

      // R7: clear wins over a same-cycle wrap
      wr(12'h100, 32'd0);
      idle(3);
      wr(12'h101, 32'd1);
      chk("R7 clear beats wrap", 32'(irq[1]), 32'd0);

      // R5: IE clear, wraps raise nothing
      wr(12'h101, 32'd0);
      idle(12);
      chk("R5 IE clear no irq", 32'(irq[1]), 32'd0);

      // R6: NH freezes under halt, and R8 write still lands
      halted = 1'b1;
      wr(12'h022, 32'd2);
      wr(12'h021, 32'd50);
      idle(5);
      rd(12'h021, v); chk("R6 frozen while halted", v, 32'd50);
      wr(12'h022, 32'd0);
      idle(2);
      rd(12'h021, v); chk("R6 NH clear ignores halt", v, 32'd52);
      halted = 1'b0;

      // R9: free-running rollover with IE
      wr(12'h023, 32'hFFFF_FFFF);
      wr(12'h022, 32'd1);
      wr(12'h021, 32'hFFFF_FFFE);
      idle(2);
      rd(12'h021, v); chk("R9 rollover to zero", v, 32'd0);
      chk("R9 rollover irq", 32'(irq[0]), 32'd1);

      // Random phase: small limits, mixed ops, toggling halt
      for (int n = 0; n < 4000; n++) begin
         int op;
         int sel;
         logic [AW-1:0] a;
         op  = $urandom_range(0, 9);
         sel = $urandom_range(0, 8);
         case (sel)
            0: a = 12'h021; 1: a = 12'h022; 2: a = 12'h023;
            3: a = 12'h100; 4: a = 12'h101; 5: a = 12'h102;
            6: a = 12'h020; 7: a = 12'h103;
            default: a = AW'($urandom());
         endcase
         halted = ($urandom_range(0, 3) == 0);
         if (op < 3) begin
            wr_en = 1'b1; addr = a;
            if (a == 12'h022 || a == 12'h101) wdata = $urandom();
            else if ($urandom_range(0, 15) == 0) wdata = $urandom();
            else wdata = 32'($urandom_range(0, 9));
         end else if (op < 6) begin
            rd_en = 1'b1; addr = a;
         end else if (op == 6) begin
            wr_en = 1'b1; rd_en = 1'b1; addr = a; wdata = 32'($urandom_range(0, 6));
         end
         @(negedge clk);
         wr_en = 1'b0; rd_en = 1'b0;
      end

      mon_on = 1'b0;
      done = 1'b1;
      summary();
      $finish;
   end
endmodule